// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block performs the hardware walk of a two-level, 4 KiB-page translation table after a translation miss. A requester gives it the physical base of the root table and a 20-bit virtual page number. The walker then fetches table entries over a read-only, AXI4-Lite-style port. It returns the final 32-bit entry zero-extended onto a 64-bit response bus, or raises an error flag. Permission checks, TLB fill and accessed/dirty updates stay with the requester. The walker leaves the entry bits exactly as read.

A walk reads the root-level entry first. A valid leaf at that level ends the walk at once. A pointer sends the walker to a second read in the table it names. Each fetched entry is checked for an illegal encoding and for a misaligned root-level leaf. Each read is watched for a bus error and for a per-read timeout. Every one of these faults ends the walk with a single error response. Only one walk runs at a time, and a synchronous flush abandons it.

Top module: `pt_walker`

## Requirements
- R1: The first read address is the root base plus four times VPN bits 19:10.
- R2: When the first entry is a pointer, the second read address is the entry's PPN (bits 31:10) shifted left by 12 and truncated to the address width, plus four times VPN bits 9:0, using the VPN latched at request time.
- R3: A valid, aligned leaf at the first level ends the walk with error low, and the block makes no second read.
- R4: Address bit 2 selects the 32-bit entry from the 64-bit read data (1 picks bits 63:32). The response carries that entry zero-extended, with every bit unchanged, including A (bit 6) and D (bit 7).
- R5: An entry with V (bit 0) low, or W (bit 2) high while R (bit 1) is low, ends the walk with error high and the entry on the response bus. So does a second-level entry with R and X (bit 3) both low.
- R6: A first-level leaf (R or X high) whose bits 19:10 are not zero ends the walk with error high and the entry on the response bus.
- R7: A read response whose code has bit 1 set ends the walk with error high and a zero entry.
- R8: A read whose data has not arrived after TIMEOUT cycles, counted from the first cycle its address valid is high, ends the walk with error high and a zero entry. The response appears in the cycle after the last counted cycle.
- R9: The read address valid stays high with a stable address until address ready is seen. At most one read is outstanding, and address valid and response valid are never high together. Both are low after reset.
- R10: A request is accepted only when the block is idle. A request raised during a walk is ignored and produces no reads and no response.
- R11: Each accepted walk produces exactly one response, and response valid is high for one cycle.
- R12: A flush aborts any walk in progress. No response follows, and the next request walks normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Abort the current walk and go idle |
| req_valid_i | input | 1 | Start a walk (taken when idle) |
| req_root_i | input | ADDR_W | Physical base of the root table |
| req_vpn_i | input | 20 | Virtual page number to translate |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_err_o | output | 1 | Walk ended in a fault, timeout or bus error |
| rsp_entry_o | output | DATA_W | Final entry, zero-extended (zero on timeout or bus error) |
| mem_ar_valid_o | output | 1 | Read address valid |
| mem_ar_addr_o | output | ADDR_W | Byte address of the entry fetch |
| mem_ar_ready_i | input | 1 | Read address accepted |
| mem_r_valid_i | input | 1 | Read data valid |
| mem_r_data_i | input | DATA_W | Read data |
| mem_r_resp_i | input | 2 | Read response code (bit 1 set means error) |

## Verification
The assertions watch, on every cycle, the protocol-level promises:
- the held, stable read address while ready is low;
- the one-cycle response strobe;
- the exclusion of address valid and response valid;
- the silence after a flush;
- an error response following an expired read timer;
- the timer never passing its budget.

Only the bench's scenarios can show which addresses are formed, which half of the data word is picked, and how each entry encoding is classified. The same holds for the exact timeout latency, for requests being ignored while busy, and for a clean walk after a flush. The bench compares each response against a reference walk of its own table model.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  localparam int PTE_W        = 32;
  localparam int VPN_FIELD_W  = 10;
  localparam int VPN_W        = 2 * VPN_FIELD_W;
  localparam int PAGE_SHIFT   = 12;
  localparam int PTE_BYTE_LOG = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } walk_st_e;

  typedef enum logic [1:0] {
    PTE_NEXT,
    PTE_LEAF,
    PTE_FAULT
  } pte_kind_e;

  typedef struct packed {
    logic d;
    logic a;
    logic g;
    logic u;
    logic x;
    logic w;
    logic r;
    logic v;
  } pte_flags_t;
endpackage

// File: rtl/pt_pte_check.sv
module pt_pte_check
  import pt_walk_pkg::*;
(
  input  logic [PTE_W-1:0] pte_i,
  input  logic             lvl_i,
  output pte_kind_e        kind_o
);
  pte_flags_t fl;
  logic       enc_ok;
  logic       is_leaf;
  logic       misaligned;

  assign fl         = pte_i[7:0];
  assign enc_ok     = fl.v && !(fl.w && !fl.r);
  assign is_leaf    = fl.r || fl.x;
  assign misaligned = !lvl_i && is_leaf && (pte_i[PAGE_SHIFT+VPN_FIELD_W-3:VPN_FIELD_W] != '0);

  always_comb begin
    if (!enc_ok || misaligned) kind_o = PTE_FAULT;
    else if (is_leaf)          kind_o = PTE_LEAF;
    else if (lvl_i)            kind_o = PTE_FAULT;
    else                       kind_o = PTE_NEXT;
  end
endmodule

// File: rtl/pt_read_timer.sv
module pt_read_timer #(
  parameter int LIMIT = 256
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clear_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i || clear_i)          cnt_q <= '0;
    else if (run_i && !expired_o)  cnt_q <= cnt_q + 1'b1;
  end

  AST_TIMER_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q < CW'(LIMIT)); // R8
endmodule

// File: rtl/pt_lane_sel.sv
module pt_lane_sel #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 32
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [((DATA_W/LANE_W) > 1 ? $clog2(DATA_W/LANE_W) : 1)-1:0] sel_i,
  output logic [LANE_W-1:0] lane_o
);
  localparam int LANES = DATA_W / LANE_W;

  logic [LANE_W-1:0] lanes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = data_i[g*LANE_W +: LANE_W];
  end

  if (LANES > 1) begin : g_multi
    assign lane_o = lanes[sel_i];
  end else begin : g_single
    assign lane_o = lanes[0];
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int TIMEOUT = 256
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              flush_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_root_i,
  input  logic [VPN_W-1:0]  req_vpn_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_entry_o,
  output logic              mem_ar_valid_o,
  output logic [ADDR_W-1:0] mem_ar_addr_o,
  input  logic              mem_ar_ready_i,
  input  logic              mem_r_valid_i,
  input  logic [DATA_W-1:0] mem_r_data_i,
  input  logic [1:0]        mem_r_resp_i
);
  localparam int LANES = DATA_W / PTE_W;
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int NB_W  = PTE_W - VPN_FIELD_W + PAGE_SHIFT;

  walk_st_e               st_q;
  logic                   lvl_q;
  logic [VPN_FIELD_W-1:0] vpn_lo_q;
  logic                   ar_valid_q;
  logic [ADDR_W-1:0]      ar_addr_q;
  logic                   rsp_valid_q;
  logic                   rsp_err_q;
  logic [DATA_W-1:0]      rsp_entry_q;

  logic [PTE_W-1:0]  sel_pte;
  logic [SEL_W-1:0]  lane_idx;
  pte_kind_e         kind;
  logic              rd_expired;
  logic              accept;
  logic              fin;
  logic              fin_err;
  logic              fin_zero;
  logic              go_l2;
  logic [NB_W-1:0]   nb_full;
  logic [ADDR_W-1:0] next_base;

  function automatic logic [ADDR_W-1:0] idx_addr(input logic [ADDR_W-1:0] base,
                                                 input logic [VPN_FIELD_W-1:0] idx);
    return base + (ADDR_W'(idx) << PTE_BYTE_LOG);
  endfunction

  if (LANES > 1) begin : g_idx
    assign lane_idx = ar_addr_q[PTE_BYTE_LOG +: SEL_W];
  end else begin : g_noidx
    assign lane_idx = '0;
  end

  pt_lane_sel #(.DATA_W(DATA_W), .LANE_W(PTE_W)) u_lane (
    .data_i (mem_r_data_i),
    .sel_i  (lane_idx),
    .lane_o (sel_pte)
  );

  pt_pte_check u_check (
    .pte_i  (sel_pte),
    .lvl_i  (lvl_q),
    .kind_o (kind)
  );

  assign accept = (st_q == ST_IDLE) && req_valid_i;

  pt_read_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .clear_i   (accept || go_l2 || flush_i),
    .run_i     (st_q != ST_IDLE),
    .expired_o (rd_expired)
  );

  assign nb_full   = {sel_pte[PTE_W-1:VPN_FIELD_W], {PAGE_SHIFT{1'b0}}};
  assign next_base = ADDR_W'(nb_full);

  always_comb begin
    fin      = 1'b0;
    fin_err  = 1'b0;
    fin_zero = 1'b0;
    go_l2    = 1'b0;
    unique case (st_q)
      ST_ISSUE: begin
        if (rd_expired) begin
          fin = 1'b1; fin_err = 1'b1; fin_zero = 1'b1;
        end
      end
      ST_WAIT: begin
        if (mem_r_valid_i) begin
          if (mem_r_resp_i[1]) begin
            fin = 1'b1; fin_err = 1'b1; fin_zero = 1'b1;
          end else if (kind == PTE_NEXT) begin
            go_l2 = 1'b1;
          end else begin
            fin     = 1'b1;
            fin_err = (kind == PTE_FAULT);
          end
        end else if (rd_expired) begin
          fin = 1'b1; fin_err = 1'b1; fin_zero = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q        <= ST_IDLE;
      lvl_q       <= 1'b0;
      vpn_lo_q    <= '0;
      ar_valid_q  <= 1'b0;
      ar_addr_q   <= '0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_entry_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      if (flush_i) begin
        st_q       <= ST_IDLE;
        ar_valid_q <= 1'b0;
      end else if (accept) begin
        st_q       <= ST_ISSUE;
        lvl_q      <= 1'b0;
        ar_valid_q <= 1'b1;
        ar_addr_q  <= idx_addr(req_root_i, req_vpn_i[VPN_W-1:VPN_FIELD_W]);
        vpn_lo_q   <= req_vpn_i[VPN_FIELD_W-1:0];
      end else if (fin) begin
        st_q        <= ST_IDLE;
        ar_valid_q  <= 1'b0;
        rsp_valid_q <= 1'b1;
        rsp_err_q   <= fin_err;
        rsp_entry_q <= fin_zero ? '0 : DATA_W'(sel_pte);
      end else if (go_l2) begin
        st_q       <= ST_ISSUE;
        lvl_q      <= 1'b1;
        ar_valid_q <= 1'b1;
        ar_addr_q  <= idx_addr(next_base, vpn_lo_q);
      end else if (st_q == ST_ISSUE && mem_ar_ready_i) begin
        st_q       <= ST_WAIT;
        ar_valid_q <= 1'b0;
      end
    end
  end

  assign mem_ar_valid_o = ar_valid_q;
  assign mem_ar_addr_o  = ar_addr_q;
  assign rsp_valid_o    = rsp_valid_q;
  assign rsp_err_o      = rsp_err_q;
  assign rsp_entry_o    = rsp_entry_q;

  AST_AR_HOLD: assert property (@(posedge clk_i) disable iff (rst_i || flush_i)
    mem_ar_valid_o && !mem_ar_ready_i && !rd_expired |=> mem_ar_valid_o && $stable(mem_ar_addr_o)); // R9
  AST_AR_RSP_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
    mem_ar_valid_o |-> !rsp_valid_o); // R9
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
    rsp_valid_o |=> !rsp_valid_o); // R11
  AST_FLUSH_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    flush_i |=> !mem_ar_valid_o && !rsp_valid_o); // R12
  AST_TIMEOUT_ERR: assert property (@(posedge clk_i) disable iff (rst_i || flush_i)
    rd_expired && !(st_q == ST_WAIT && mem_r_valid_i) |=> rsp_valid_o && rsp_err_o); // R8
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int TMO    = 24;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst = 1'b1;
  logic              flush = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_root = '0;
  logic [19:0]       req_vpn = '0;
  logic              rsp_valid_o, rsp_err_o;
  logic [DATA_W-1:0] rsp_entry_o;
  logic              mem_ar_valid_o;
  logic [ADDR_W-1:0] mem_ar_addr_o;
  logic              ar_ready = 1'b0;
  logic              r_valid = 1'b0;
  logic [DATA_W-1:0] r_data = '0;
  logic [1:0]        r_resp = '0;

  pt_walker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT(TMO)) dut_i (
    .clk_i(clk), .rst_i(rst), .flush_i(flush),
    .req_valid_i(req_valid), .req_root_i(req_root), .req_vpn_i(req_vpn),
    .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o), .rsp_entry_o(rsp_entry_o),
    .mem_ar_valid_o(mem_ar_valid_o), .mem_ar_addr_o(mem_ar_addr_o), .mem_ar_ready_i(ar_ready),
    .mem_r_valid_i(r_valid), .mem_r_data_i(r_data), .mem_r_resp_i(r_resp)
  );

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // table memory model, 64-bit words keyed by byte address >> 3
  logic [63:0] mem [logic [31:0]];

  function automatic logic [31:0] rd32(input logic [31:0] a);
    logic [63:0] w;
    w = mem.exists(a >> 3) ? mem[a >> 3] : 64'h0;
    return a[2] ? w[63:32] : w[31:0];
  endfunction

  task automatic put32(input logic [31:0] a, input logic [31:0] v);
    logic [63:0] w;
    w = mem.exists(a >> 3) ? mem[a >> 3] : 64'hA5A5_5A5A_C3C3_3C3C;
    if (a[2]) w[63:32] = v; else w[31:0] = v;
    mem[a >> 3] = w;
  endtask

  // memory responder
  int          ar_lat = 0;
  int          r_lat = 0;
  bit          drop = 1'b0;
  logic [1:0]  rresp = 2'b00;
  logic [31:0] ar_log [$];
  logic [31:0] cur_a;

  initial begin
    forever begin
      @(negedge clk);
      if (mem_ar_valid_o) begin
        cur_a = mem_ar_addr_o;
        repeat (ar_lat) @(negedge clk);
        ar_ready = 1'b1;
        @(negedge clk);
        ar_ready = 1'b0;
        ar_log.push_back(cur_a);
        if (!drop) begin
          repeat (r_lat) @(negedge clk);
          r_valid = 1'b1;
          r_data  = mem.exists(cur_a >> 3) ? mem[cur_a >> 3] : 64'h0;
          r_resp  = rresp;
          @(negedge clk);
          r_valid = 1'b0;
          r_resp  = 2'b00;
        end
      end
    end
  end

  // scoreboard
  typedef struct {
    logic        err;
    logic [63:0] entry;
    string       rq;
  } exp_t;
  exp_t sb [$];
  exp_t cur_e;
  int   rsp_cnt = 0;

  always @(negedge clk) begin
    if (!rst && rsp_valid_o) begin
      rsp_cnt++;
      if (sb.size() == 0) begin
        chk(1'b0, "R11", "unexpected response", 64'd1, 64'd0);
      end else begin
        cur_e = sb.pop_front();
        chk(rsp_err_o === cur_e.err, cur_e.rq, "error flag", 64'(rsp_err_o), 64'(cur_e.err));
        chk(rsp_entry_o === cur_e.entry, cur_e.rq, "entry", rsp_entry_o, cur_e.entry);
      end
    end
  end

  // reference walk built from the requirements
  task automatic ref_walk(input logic [31:0] root, input logic [19:0] vpn,
                          output logic err, output logic [63:0] ent, output int nrd,
                          output logic [31:0] a1, output logic [31:0] a2);
    logic [31:0] p, q;
    logic [33:0] nb;
    a1  = root + {20'h0, vpn[19:10], 2'b00};
    a2  = '0;
    p   = rd32(a1);
    nrd = 1;
    ent = {32'h0, p};
    if (!p[0] || (p[2] && !p[1])) begin
      err = 1'b1;
    end else if (p[1] || p[3]) begin
      err = (p[19:10] != 10'h0);
    end else begin
      nb  = {p[31:10], 12'h000};
      a2  = nb[31:0] + {20'h0, vpn[9:0], 2'b00};
      q   = rd32(a2);
      nrd = 2;
      ent = {32'h0, q};
      err = !q[0] || (q[2] && !q[1]) || !(q[1] || q[3]);
    end
  endtask

  task automatic walk_core(input logic [31:0] root, input logic [19:0] vpn,
                           input logic err, input logic [63:0] ent, input int nrd,
                           input logic [31:0] a1, input logic [31:0] a2,
                           input string rq, output int lat);
    int n0;
    sb.push_back('{err, ent, rq});
    ar_log.delete();
    n0 = rsp_cnt;
    req_root  = root;
    req_vpn   = vpn;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid_o && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    @(negedge clk);
    chk(rsp_cnt == n0 + 1, "R11", {rq, " response count"}, 64'(rsp_cnt - n0), 64'd1);
    chk(ar_log.size() == nrd, (nrd == 1) ? "R3" : "R2", {rq, " read count"},
        64'(ar_log.size()), 64'(nrd));
    if (ar_log.size() >= 1)
      chk(ar_log[0] == a1, "R1", {rq, " first address"}, 64'(ar_log[0]), 64'(a1));
    if (nrd == 2 && ar_log.size() >= 2)
      chk(ar_log[1] == a2, "R2", {rq, " second address"}, 64'(ar_log[1]), 64'(a2));
  endtask

  task automatic walk(input logic [31:0] root, input logic [19:0] vpn, input string rq);
    logic err; logic [63:0] ent; int nrd; logic [31:0] a1, a2; int lat;
    ref_walk(root, vpn, err, ent, nrd, a1, a2);
    walk_core(root, vpn, err, ent, nrd, a1, a2, rq, lat);
  endtask

  localparam logic [31:0] ROOT = 32'h0001_0000;

  initial begin : wd
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int lat;
    int n0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_ar_valid_o == 1'b0, "R9", "reset address valid", 64'(mem_ar_valid_o), 64'd0);
    chk(rsp_valid_o == 1'b0, "R11", "reset response valid", 64'(rsp_valid_o), 64'd0);

    // table contents
    put32(ROOT + 32'h0C, 32'h0000_8001);            // vpn1=3: pointer to 0x20000
    put32(32'h0002_0014, 32'h0004_8CCF);            // vpn0=5: leaf, A and D set (upper half)
    put32(32'h0002_0008, 32'h0005_0003);            // vpn0=2: leaf in lower half
    put32(ROOT + 32'h10, 32'h0010_0003);            // vpn1=4: aligned first-level leaf
    put32(ROOT + 32'h18, 32'h0010_040B);            // vpn1=6: misaligned leaf
    put32(ROOT + 32'h20, 32'h0000_8000);            // vpn1=8: V low
    put32(ROOT + 32'h24, 32'h0000_0005);            // vpn1=9: W without R
    put32(ROOT + 32'h28, 32'h0000_8401);            // vpn1=10: pointer to 0x21000
    put32(32'h0002_101C, 32'h0000_9001);            // vpn0=7: pointer at second level

    walk(ROOT, {10'd3, 10'd5}, "R4 two-level upper lane A/D kept");
    walk(ROOT, {10'd3, 10'd2}, "R4 two-level lower lane");
    ar_lat = 3; r_lat = 5;
    walk(ROOT, {10'd3, 10'd5}, "R2 two-level slow memory");
    ar_lat = 1; r_lat = 2;
    walk(ROOT, {10'd4, 10'd9}, "R3 first-level leaf");
    ar_lat = 0; r_lat = 0;
    walk(ROOT, {10'd6, 10'd0}, "R6 misaligned leaf");
    walk(ROOT, {10'd8, 10'd1}, "R5 valid bit low");
    walk(ROOT, {10'd9, 10'd1}, "R5 write without read");
    walk(ROOT, {10'd10, 10'd7}, "R5 pointer at second level");

    // R7 bus error on first read
    rresp = 2'b10;
    walk_core(ROOT, {10'd3, 10'd5}, 1'b1, 64'h0, 1, ROOT + 32'h0C, 32'h0, "R7 bus error", lat);
    rresp = 2'b00;

    // R8 timeout with no read data
    drop = 1'b1;
    walk_core(ROOT, {10'd3, 10'd5}, 1'b1, 64'h0, 1, ROOT + 32'h0C, 32'h0, "R8 timeout", lat);
    chk(lat == TMO + 1, "R8", "timeout latency", 64'(lat), 64'(TMO + 1));

    // R12 flush mid-walk
    n0 = rsp_cnt;
    req_root = ROOT; req_vpn = {10'd3, 10'd5}; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    @(negedge clk);
    chk(mem_ar_valid_o == 1'b0, "R12", "address valid after flush", 64'(mem_ar_valid_o), 64'd0);
    repeat (TMO + 6) @(negedge clk);
    chk(rsp_cnt == n0, "R12", "no response after flush", 64'(rsp_cnt - n0), 64'd0);
    drop = 1'b0;
    walk(ROOT, {10'd3, 10'd5}, "R12 walk after flush");

    // R10 request during a busy walk is ignored
    r_lat = 6;
    n0 = rsp_cnt;
    fork
      walk(ROOT, {10'd3, 10'd5}, "R10 first walk kept");
      begin
        repeat (3) @(negedge clk);
        req_valid = 1'b1;
        req_vpn   = {10'd4, 10'd2};
        @(negedge clk);
        req_valid = 1'b0;
      end
    join
    repeat (40) @(negedge clk);
    chk(rsp_cnt == n0 + 1, "R10", "responses for busy request", 64'(rsp_cnt - n0), 64'd1);
    chk(ar_log.size() == 2, "R10", "reads for busy request", 64'(ar_log.size()), 64'd2);
    chk(sb.size() == 0, "R11", "pending expectations", 64'(sb.size()), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule